// File: doc/BRIEF.md
# Sector Group Unprotect Pulse Sequencer

This controller runs the repeat-until-verified algorithm that removes write protection from every sector group of a flash array. A host pulses `start` together with the data of the first command write. The block waits a settle time counted in microsecond ticks and then issues that first command. It protects any group that is still unprotected, so that all groups begin in the same state. It then applies chip-wide unprotect pulses and reads back each group in turn after every pulse.

Each pulse is counted. If the pulse limit is reached while some group still reads protected, the block stops and reports a device failure. If every group reads cleared, it reports success. A behavioural register with one protect bit per group stands in for the array. Host loads set this register. Protect pulses set one bit. Unprotect pulses clear the bits of the groups whose cells respond.

Top module: `usp_seq`

## Requirements
- R1: On `start` the block latches `first_data` and counts exactly ENTRY_US microsecond ticks. Next it issues its first command. If the latched value is 60h it strobes `cmd_code`=60h. With any other value it returns to idle with no strobe, no `pass` or `fail`, and `prot_state` unchanged.
- R2: In the protect phase each group whose bit reads 0 gets one protect pulse: a 60h strobe with `pulse_unprot` low, then `pulse_on` high for exactly PROT_US ticks, then a 40h verify strobe. That pulse sets the group's bit. Groups already at 1 get no pulse.
- R3: Each unprotect pulse is a 60h strobe with `pulse_unprot` high, then `pulse_on` high for exactly UNPROT_US ticks, then a 40h verify strobe. At the end of the pulse, every group g with `cell_resp[g]` high has its bit cleared.
- R4: Verification moves `grp_idx` from 0 upward, one group at a time, and advances only when the group's bit reads 0. After a failed verify, the next pulse is followed by another check of the same group. At pass, `grp_idx` is the last group.
- R5: `attempt_cnt` is 0 after reset and cleared on `start`. It is set to 1 at the first unprotect pulse and incremented after each failed verify, so at pass it equals the number of unprotect pulses.
- R6: If a verify fails while `attempt_cnt` equals MAX_PULSES (1000 by default), `fail` pulses and no further pulse is issued. `attempt_cnt` then shows MAX_PULSES and `grp_idx` shows the failing group. A group that clears on exactly the last pulse still passes.
- R7: `busy` is high from the cycle after `start` until the cycle in which `pass` or `fail` is high, and it is low in that cycle. `pass` and `fail` are never both high. Each lasts one cycle. `pass` comes only when every bit reads 0.
- R8: A synchronous reset returns the block to idle with `attempt_cnt`=0, `grp_idx`=0 and all outputs low. It leaves `prot_state` unchanged, even in the middle of a pulse.
- R9: `model_load` writes `model_val` into the protect bits on the next edge. While idle and not loading, the bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a sequence (taken when idle) |
| first_data | input | 8 | Data of the first command write, latched with `start` |
| us_tick | input | 1 | One-cycle strobe each microsecond |
| cell_resp | input | NUM_GROUPS | Per-group cell response applied at the end of an unprotect pulse |
| model_load | input | 1 | Load the protect-bit model |
| model_val | input | NUM_GROUPS | Value loaded into the model |
| cmd_strobe | output | 1 | One-cycle command issue strobe |
| cmd_code | output | 8 | 60h pulse/entry command or 40h verify, valid with strobe |
| pulse_on | output | 1 | A timed pulse is being applied |
| pulse_unprot | output | 1 | Current pulse (or its start strobe) is an unprotect pulse |
| grp_idx | output | GW | Group being checked |
| attempt_cnt | output | ACW | Unprotect pulse attempt counter |
| prot_state | output | NUM_GROUPS | Protect bits of the model, one per group |
| busy | output | 1 | Sequence in progress |
| pass | output | 1 | One-cycle success pulse |
| fail | output | 1 | One-cycle device-failed pulse |

## Verification
The bench targets the case where a group clears on exactly the 1000th pulse and the case where it clears one pulse later. A counter that is off by one fails the first case or passes the second. It loads groups that are already protected and checks that they get no protect pulse. It counts ticks inside each pulse and during the entry wait, which exposes a timer that ends one tick early or late. Reset is applied in the middle of a pulse to catch a model that changes or a counter that keeps its value. Random per-group response delays check that a walk which went back to group 0 after a failed verify, or skipped a group that still reads protected, would report the wrong pulse count or a wrong pass.

// File: rtl/usp_pkg.sv
package usp_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ENTRY,
      ST_FIRST,
      ST_PCHK,
      ST_PSTART,
      ST_PPULSE,
      ST_PVFY,
      ST_USTART,
      ST_UPULSE,
      ST_UVFY,
      ST_UCHK,
      ST_PASS,
      ST_FAIL
   } seq_state_t;

   localparam logic [7:0] CMD_PULSE  = 8'h60;
   localparam logic [7:0] CMD_VERIFY = 8'h40;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/usp_us_timer.sv
module usp_us_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          run,
   input  logic          tick,
   input  logic [CW-1:0] limit,
   output logic          done
);

   logic [CW-1:0] cnt_q;
   logic          last_tick;

   assign last_tick = (cnt_q == limit - CW'(1));
   assign done      = run && tick && last_tick;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (run && tick) begin
         if (last_tick) begin
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + CW'(1);
         end
      end
   end

endmodule

// File: rtl/usp_attempt_ctr.sv
module usp_attempt_ctr #(
   parameter int MAX_PULSES = 1000,
   parameter int ACW        = 10
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           clr,
   input  logic           init,
   input  logic           inc,
   output logic [ACW-1:0] cnt,
   output logic           at_max
);

   localparam logic [ACW-1:0] LIMIT = ACW'(MAX_PULSES);

   logic [ACW-1:0] cnt_q;

   assign cnt    = cnt_q;
   assign at_max = (cnt_q == LIMIT);

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         cnt_q <= '0;
      end else if (init) begin
         cnt_q <= ACW'(1);
      end else if (inc && !at_max) begin
         cnt_q <= cnt_q + ACW'(1);
      end
   end

endmodule

// File: rtl/usp_prot_model.sv
module usp_prot_model #(
   parameter int NUM_GROUPS = 8,
   parameter int GW         = 3
) (
   input  logic                  clk,
   input  logic                  load,
   input  logic [NUM_GROUPS-1:0] load_val,
   input  logic                  set_en,
   input  logic [GW-1:0]         set_idx,
   input  logic                  clr_en,
   input  logic [NUM_GROUPS-1:0] clr_mask,
   output logic [NUM_GROUPS-1:0] bits
);

   // One storage bit per group; deliberately no reset so that the
   // array state survives a controller reset.
   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bit
      logic bit_q;
      logic hit_set;
      assign hit_set = set_en && (set_idx == GW'(g));
      always_ff @(posedge clk) begin
         if (load) begin
            bit_q <= load_val[g];
         end else if (hit_set) begin
            bit_q <= 1'b1;
         end else if (clr_en && clr_mask[g]) begin
            bit_q <= 1'b0;
         end
      end
      assign bits[g] = bit_q;
   end

endmodule

// File: rtl/usp_seq.sv
module usp_seq #(
   parameter int NUM_GROUPS = 8,
   parameter int MAX_PULSES = 1000,
   parameter int ENTRY_US   = 1,
   parameter int PROT_US    = 150,
   parameter int UNPROT_US  = 10000,
   localparam int GW  = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
   localparam int ACW = $clog2(MAX_PULSES + 1)
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  start,
   input  logic [7:0]            first_data,
   input  logic                  us_tick,
   input  logic [NUM_GROUPS-1:0] cell_resp,
   input  logic                  model_load,
   input  logic [NUM_GROUPS-1:0] model_val,
   output logic                  cmd_strobe,
   output logic [7:0]            cmd_code,
   output logic                  pulse_on,
   output logic                  pulse_unprot,
   output logic [GW-1:0]         grp_idx,
   output logic [ACW-1:0]        attempt_cnt,
   output logic [NUM_GROUPS-1:0] prot_state,
   output logic                  busy,
   output logic                  pass,
   output logic                  fail
);

   import usp_pkg::*;

   localparam int TMAX = max3(ENTRY_US, PROT_US, UNPROT_US);
   localparam int TCW  = $clog2(TMAX + 1);
   localparam logic [GW-1:0] LAST_GRP = GW'(NUM_GROUPS - 1);

   // elaboration-time parameter checks
   if (NUM_GROUPS < 1) begin : g_chk_groups
      $error("usp_seq: NUM_GROUPS must be at least 1");
   end
   if (MAX_PULSES < 1) begin : g_chk_pulses
      $error("usp_seq: MAX_PULSES must be at least 1");
   end
   if (ENTRY_US < 1 || PROT_US < 1 || UNPROT_US < 1) begin : g_chk_times
      $error("usp_seq: every pulse or wait length must be at least 1 tick");
   end

   seq_state_t     state_q, state_d;
   logic [GW-1:0]  grp_q, grp_d;
   logic [7:0]     data_q;
   logic           tmr_run, tmr_done;
   logic [TCW-1:0] tmr_limit;
   logic           att_clr, att_init, att_inc, att_max;
   logic           mdl_set, mdl_clr;
   logic           cur_prot;

   assign cur_prot = prot_state[grp_q];

   // -------------------------------------------------- timer
   always_comb begin
      case (state_q)
         ST_ENTRY:  tmr_limit = TCW'(ENTRY_US);
         ST_PPULSE: tmr_limit = TCW'(PROT_US);
         default:   tmr_limit = TCW'(UNPROT_US);
      endcase
   end

   assign tmr_run = (state_q == ST_ENTRY) || (state_q == ST_PPULSE) ||
                    (state_q == ST_UPULSE);

   usp_us_timer #(.CW(TCW)) u_timer (
      .clk   (clk),
      .rst   (rst),
      .run   (tmr_run),
      .tick  (us_tick),
      .limit (tmr_limit),
      .done  (tmr_done)
   );

   // -------------------------------------------------- sequencing
   always_comb begin
      state_d  = state_q;
      grp_d    = grp_q;
      att_clr  = 1'b0;
      att_init = 1'b0;
      att_inc  = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (start) begin
               state_d = ST_ENTRY;
               grp_d   = '0;
               att_clr = 1'b1;
            end
         end
         ST_ENTRY: begin
            if (tmr_done) state_d = ST_FIRST;
         end
         ST_FIRST: begin
            state_d = (data_q == CMD_PULSE) ? ST_PCHK : ST_IDLE;
         end
         ST_PCHK: begin
            if (!cur_prot) begin
               state_d = ST_PSTART;
            end else if (grp_q == LAST_GRP) begin
               state_d  = ST_USTART;
               grp_d    = '0;
               att_init = 1'b1;
            end else begin
               grp_d = grp_q + GW'(1);
            end
         end
         ST_PSTART: state_d = ST_PPULSE;
         ST_PPULSE: begin
            if (tmr_done) state_d = ST_PVFY;
         end
         ST_PVFY:   state_d = ST_PCHK;
         ST_USTART: state_d = ST_UPULSE;
         ST_UPULSE: begin
            if (tmr_done) state_d = ST_UVFY;
         end
         ST_UVFY:   state_d = ST_UCHK;
         ST_UCHK: begin
            if (!cur_prot) begin
               if (grp_q == LAST_GRP) begin
                  state_d = ST_PASS;
               end else begin
                  grp_d = grp_q + GW'(1);
               end
            end else if (att_max) begin
               state_d = ST_FAIL;
            end else begin
               att_inc = 1'b1;
               state_d = ST_USTART;
            end
         end
         ST_PASS:  state_d = ST_IDLE;
         ST_FAIL:  state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         grp_q   <= '0;
         data_q  <= '0;
      end else begin
         state_q <= state_d;
         grp_q   <= grp_d;
         if (state_q == ST_IDLE && start) begin
            data_q <= first_data;
         end
      end
   end

   usp_attempt_ctr #(.MAX_PULSES(MAX_PULSES), .ACW(ACW)) u_attempts (
      .clk    (clk),
      .rst    (rst),
      .clr    (att_clr),
      .init   (att_init),
      .inc    (att_inc),
      .cnt    (attempt_cnt),
      .at_max (att_max)
   );

   // -------------------------------------------------- array model
   assign mdl_set = !rst && (state_q == ST_PPULSE) && tmr_done;
   assign mdl_clr = !rst && (state_q == ST_UPULSE) && tmr_done;

   usp_prot_model #(.NUM_GROUPS(NUM_GROUPS), .GW(GW)) u_model (
      .clk      (clk),
      .load     (model_load),
      .load_val (model_val),
      .set_en   (mdl_set),
      .set_idx  (grp_q),
      .clr_en   (mdl_clr),
      .clr_mask (cell_resp),
      .bits     (prot_state)
   );

   // -------------------------------------------------- outputs
   always_comb begin
      cmd_strobe = 1'b0;
      cmd_code   = 8'h00;
      case (state_q)
         ST_FIRST: begin
            if (data_q == CMD_PULSE) begin
               cmd_strobe = 1'b1;
               cmd_code   = CMD_PULSE;
            end
         end
         ST_PSTART, ST_USTART: begin
            cmd_strobe = 1'b1;
            cmd_code   = CMD_PULSE;
         end
         ST_PVFY, ST_UVFY: begin
            cmd_strobe = 1'b1;
            cmd_code   = CMD_VERIFY;
         end
         default: ;
      endcase
   end

   assign pulse_on     = (state_q == ST_PPULSE) || (state_q == ST_UPULSE);
   assign pulse_unprot = (state_q == ST_USTART) || (state_q == ST_UPULSE);
   assign grp_idx      = grp_q;
   assign busy         = (state_q != ST_IDLE) && (state_q != ST_PASS) &&
                         (state_q != ST_FAIL);
   assign pass         = (state_q == ST_PASS);
   assign fail         = (state_q == ST_FAIL);

endmodule

// File: rtl/usp_seq_chk.sv
module usp_seq_chk #(
   parameter int NUM_GROUPS = 8,
   parameter int MAX_PULSES = 1000,
   parameter int GW         = 3,
   parameter int ACW        = 10
) (
   input logic                  clk,
   input logic                  rst,
   input logic                  start,
   input logic                  model_load,
   input logic                  cmd_strobe,
   input logic [7:0]            cmd_code,
   input logic                  pulse_on,
   input logic                  pulse_unprot,
   input logic [ACW-1:0]        attempt_cnt,
   input logic [NUM_GROUPS-1:0] prot_state,
   input logic                  busy,
   input logic                  pass,
   input logic                  fail
);

   AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (rst)
      cmd_strobe |-> (cmd_code == 8'h60 || cmd_code == 8'h40));      // R1

   AST_PULSE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
      pulse_on |-> busy);                                            // R3

   AST_UNPROT_COUNTED: assert property (@(posedge clk) disable iff (rst)
      (pulse_on && pulse_unprot) |-> (attempt_cnt != '0));           // R5

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
      attempt_cnt <= ACW'(MAX_PULSES));                              // R5

   AST_FAIL_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
      fail |-> (attempt_cnt == ACW'(MAX_PULSES)));                   // R6

   AST_PASS_FAIL_EXCL: assert property (@(posedge clk) disable iff (rst)
      !(pass && fail));                                              // R7

   AST_PASS_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      pass |=> !pass);                                               // R7

   AST_FAIL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      fail |=> !fail);                                               // R7

   AST_END_DROPS_BUSY: assert property (@(posedge clk) disable iff (rst)
      (pass || fail) |-> (!busy && $past(busy)));                    // R7

   AST_PASS_CLEARED: assert property (@(posedge clk) disable iff (rst)
      pass |-> (prot_state == '0));                                  // R7

   AST_IDLE_MODEL_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!busy && !model_load && !start) |=> $stable(prot_state));     // R9

endmodule

bind usp_seq usp_seq_chk #(
   .NUM_GROUPS (NUM_GROUPS),
   .MAX_PULSES (MAX_PULSES),
   .GW         (GW),
   .ACW        (ACW)
) u_usp_seq_chk (
   .clk          (clk),
   .rst          (rst),
   .start        (start),
   .model_load   (model_load),
   .cmd_strobe   (cmd_strobe),
   .cmd_code     (cmd_code),
   .pulse_on     (pulse_on),
   .pulse_unprot (pulse_unprot),
   .attempt_cnt  (attempt_cnt),
   .prot_state   (prot_state),
   .busy         (busy),
   .pass         (pass),
   .fail         (fail)
);

// File: tb/test_usp_seq.sv
module test_usp_seq;

   localparam int CLK_PERIOD = 10;
   localparam int NG     = 8;
   localparam int ENTRY  = 1;
   localparam int PROT   = 6;
   localparam int UNPROT = 4;
   localparam int MAXP   = 1000;
   localparam int GW     = 3;
   localparam int ACW    = $clog2(MAXP + 1);
   localparam int WD_CYCLES = 190000;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          start = 1'b0;
   logic [7:0]    first_data = 8'h00;
   logic          us_tick = 1'b0;
   logic [NG-1:0] cell_resp;
   logic          model_load = 1'b0;
   logic [NG-1:0] model_val = '0;
   logic          cmd_strobe;
   logic [7:0]    cmd_code;
   logic          pulse_on, pulse_unprot;
   logic [GW-1:0] grp_idx;
   logic [ACW-1:0] attempt_cnt;
   logic [NG-1:0] prot_state;
   logic          busy, pass, fail;

   int nchk = 0;
   int nerr = 0;
   int tick_pct = 100;
   int kreq [NG];
   logic mon_clr = 1'b0;

   // monitor counters
   int u_seen, p_seen, n60_first, n40, etick, ptick, width_bad, dec_cnt;
   int n_pass, n_fail;
   logic seen_first, pon_d, kind_d;
   logic [GW-1:0] grp_last;

   always #(CLK_PERIOD/2) clk = ~clk;

   usp_seq #(
      .NUM_GROUPS (NG),
      .MAX_PULSES (MAXP),
      .ENTRY_US   (ENTRY),
      .PROT_US    (PROT),
      .UNPROT_US  (UNPROT)
   ) i_usp_seq (
      .clk (clk), .rst (rst), .start (start), .first_data (first_data),
      .us_tick (us_tick), .cell_resp (cell_resp), .model_load (model_load),
      .model_val (model_val), .cmd_strobe (cmd_strobe), .cmd_code (cmd_code),
      .pulse_on (pulse_on), .pulse_unprot (pulse_unprot), .grp_idx (grp_idx),
      .attempt_cnt (attempt_cnt), .prot_state (prot_state), .busy (busy),
      .pass (pass), .fail (fail)
   );

   // a group responds once it has seen kreq[g] unprotect pulses (R3)
   always_comb begin
      for (int g = 0; g < NG; g++) cell_resp[g] = (u_seen >= kreq[g]);
   end

   initial begin
      forever begin
         @(posedge clk);
         #1;
         us_tick = ($urandom_range(99) < tick_pct);
      end
   end

   always @(negedge clk) begin
      if (mon_clr) begin
         u_seen = 0; p_seen = 0; n60_first = 0; n40 = 0; etick = 0;
         ptick = 0; width_bad = 0; dec_cnt = 0; n_pass = 0; n_fail = 0;
         seen_first = 1'b0; pon_d = 1'b0; kind_d = 1'b0; grp_last = '0;
      end else begin
         if (busy && !cmd_strobe && !seen_first && us_tick) etick++;
         if (cmd_strobe) begin
            if (cmd_code == 8'h40) n40++;
            else if (pulse_unprot) u_seen++;
            else if (!seen_first) n60_first++;
            else p_seen++;
            seen_first = 1'b1;
         end
         if (pulse_on && us_tick) ptick++;
         if (pon_d && !pulse_on) begin
            if (ptick != (kind_d ? UNPROT : PROT)) width_bad++;
            ptick = 0;
         end
         pon_d = pulse_on;
         if (pulse_on) kind_d = pulse_unprot;
         if (busy) begin
            if (grp_idx < grp_last) dec_cnt++;
            grp_last = grp_idx;
         end
         if (pass) n_pass++;
         if (fail) n_fail++;
      end
   end

   initial begin
      #(CLK_PERIOD * WD_CYCLES);
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", nerr + 1, nchk + 1);
      $finish;
   end

   task automatic chk(input string req, input longint act, input longint exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int popz(input logic [NG-1:0] v);
      int n = 0;
      for (int g = 0; g < NG; g++) if (!v[g]) n++;
      return n;
   endfunction

   function automatic int kmax();
      int m = 1;
      for (int g = 0; g < NG; g++) if (kreq[g] > m) m = kreq[g];
      return m;
   endfunction

   function automatic int fail_grp();
      for (int g = 0; g < NG; g++) if (kreq[g] > MAXP) return g;
      return -1;
   endfunction

   function automatic logic [NG-1:0] left_mask();
      logic [NG-1:0] m = '0;
      for (int g = 0; g < NG; g++) if (kreq[g] > MAXP) m[g] = 1'b1;
      return m;
   endfunction

   task automatic load_model(input logic [NG-1:0] v);
      @(posedge clk); #1;
      model_load = 1'b1; model_val = v;
      @(posedge clk); #1;
      model_load = 1'b0;
   endtask

   task automatic kick(input logic [7:0] d);
      @(posedge clk); #1;
      mon_clr = 1'b1;
      @(posedge clk); #1;
      mon_clr = 1'b0; start = 1'b1; first_data = d;
      @(posedge clk); #1;
      start = 1'b0;
   endtask

   task automatic full_run(input string tag, input logic [NG-1:0] pre);
      int n = 0;
      int p;
      logic exp_fail;
      load_model(pre);
      kick(8'h60);
      do begin
         @(negedge clk); n++;
      end while (!(pass || fail) && n < 60000);
      chk({tag, " R7 run ends"}, n < 60000, 1);
      p = kmax();
      exp_fail = (p > MAXP);
      chk({tag, " R7 busy low at end"}, busy, 0);
      chk({tag, " R6 fail flag"}, fail, exp_fail);
      chk({tag, " R5 attempt count"}, attempt_cnt, exp_fail ? MAXP : p);
      if (exp_fail) chk({tag, " R6 failing group"}, grp_idx, fail_grp());
      else          chk({tag, " R4 last group at pass"}, grp_idx, NG - 1);
      chk({tag, " R3 bits left"}, prot_state, exp_fail ? left_mask() : '0);
      @(negedge clk);
      chk({tag, " R7 single end pulse"}, n_pass + n_fail, 1);
      chk({tag, " R1 entry ticks"}, etick, ENTRY);
      chk({tag, " R1 first command"}, n60_first, 1);
      chk({tag, " R2 protect pulses"}, p_seen, popz(pre));
      chk({tag, " R3 unprotect pulses"}, u_seen, exp_fail ? MAXP : p);
      chk({tag, " R2 verify strobes"}, n40, popz(pre) + (exp_fail ? MAXP : p));
      chk({tag, " R3 pulse widths"}, width_bad, 0);
      chk({tag, " R4 walk restarts once"}, dec_cnt, (NG > 1) ? 1 : 0);
   endtask

   initial begin
      logic [NG-1:0] snap;
      int n;
      void'($urandom(32'h0000_5eed));
      for (int g = 0; g < NG; g++) kreq[g] = 1;

      // R8: reset state, model untouched by reset
      load_model(8'hA5);
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R8 reset busy", busy, 0);
      chk("R8 reset pass/fail", {pass, fail}, 0);
      chk("R8 reset strobe", cmd_strobe, 0);
      chk("R8 reset attempt", attempt_cnt, 0);
      chk("R8 reset group", grp_idx, 0);
      chk("R9 model kept over reset", prot_state, 8'hA5);
      @(posedge clk); #1 rst = 1'b0;

      // R1: wrong first data aborts
      load_model(8'h3C);
      kick(8'h55);
      n = 0;
      do begin
         @(negedge clk); n++;
      end while (busy && n < 100);
      repeat (2) @(negedge clk);
      chk("R1 abort returns idle", busy, 0);
      chk("R1 abort no strobes", u_seen + p_seen + n60_first + n40, 0);
      chk("R1 abort no result", n_pass + n_fail, 0);
      chk("R1 abort model unchanged", prot_state, 8'h3C);

      // directed: all already protected, every group responds at once
      tick_pct = 100;
      full_run("all-protected", 8'hFF);
      // directed: nothing protected, staggered responses
      for (int g = 0; g < NG; g++) kreq[g] = NG - g;
      tick_pct = 60;
      full_run("none-protected", 8'h00);
      // boundary: clears on exactly the last allowed pulse
      tick_pct = 100;
      for (int g = 0; g < NG; g++) kreq[g] = 2;
      kreq[3] = MAXP;
      full_run("limit-pass", 8'h0F);
      // boundary: one pulse too many -> device failed at group 5
      for (int g = 0; g < NG; g++) kreq[g] = 3;
      kreq[5] = MAXP + 1;
      kreq[6] = MAXP + 7;
      full_run("limit-fail", 8'hF0);

      // random trials
      for (int t = 0; t < 6; t++) begin
         logic [NG-1:0] pre;
         pre = NG'($urandom);
         for (int g = 0; g < NG; g++) kreq[g] = 1 + $urandom_range(29);
         tick_pct = 30 + $urandom_range(70);
         full_run($sformatf("random%0d", t), pre);
      end

      // R8: reset in the middle of an unprotect pulse
      for (int g = 0; g < NG; g++) kreq[g] = 50;
      tick_pct = 20;
      load_model(8'h81);
      kick(8'h60);
      n = 0;
      do begin
         @(negedge clk); n++;
      end while (!(pulse_on && pulse_unprot && attempt_cnt == 3) && n < 5000);
      snap = prot_state;
      tick_pct = 100;
      rst = 1'b1;
      @(posedge clk); #1 rst = 1'b0;
      @(negedge clk);
      chk("R8 mid-run busy", busy, 0);
      chk("R8 mid-run attempt", attempt_cnt, 0);
      chk("R8 mid-run pulse", pulse_on, 0);
      chk("R8 mid-run model", prot_state, snap);

      // R9: load while idle
      load_model(8'h5A);
      @(negedge clk);
      chk("R9 load value", prot_state, 8'h5A);

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule